// File: doc/BRIEF.md
# Configurable UART Frame Transmitter

This block turns one character at a time into an asynchronous serial frame. A 16x bit-rate enable pulse (`tick16`) sets the timing: each bit cell lasts sixteen enable pulses. Characters arrive through a valid/ready handshake into a single holding slot that sits in front of the shift stage. While one character is being sent, the next one can wait in the slot.

The frame shape comes from static configuration inputs: a character length of 5 to 8 data bits, one of five parity choices, and a stop length of one, one and a half or two bit cells. Commands can force a break, which holds the line low. An enable makes the block wait for clear-to-send before starting each character. Another enable raises an RTS output for as long as transmit work is pending. A routing selector connects the transmitter, the external receive pin and the receiver-side line in one of four ways: normal, automatic echo, local loopback or remote loopback.

The configuration inputs are read when a character starts. Software is expected to change them only while `tx_empty` is high.

Top module: `uart_frame_tx`

## Requirements
- R1: `cfg_len` sets the number of data bits. 0 gives 5 bits, 1 gives 6, 2 gives 7 and 3 gives 8. Data bits leave least significant bit first, and bits of `tx_data` above the selected length are not sent.
- R2: `cfg_par` sets the parity bit that follows the data. 3'b000 gives even parity over the sent data bits, 3'b001 gives odd parity, 3'b010 gives a constant 0 and 3'b011 gives a constant 1. Any code with bit 2 set sends no parity bit.
- R3: `cfg_stop` sets the stop length in `tick16` pulses. 4'h7 gives 16, 4'h8 gives 24, 4'hF gives 32, and every other code gives 16. With back-to-back characters, the line is high for exactly that many pulses between frames.
- R4: A frame is a low start bit, then the data bits, then the optional parity bit, then the high stop time. Each bit other than the stop time lasts exactly 16 `tick16` pulses. The idle line is high.
- R5: `tx_ready` is high exactly when the holding slot is free. A character is taken on a clock where `tx_valid` and `tx_ready` are both high. One character can wait in the slot while another is being shifted out.
- R6: `tx_empty` is high exactly when the slot is free and no frame is being shifted. This includes the whole time a break is held with nothing queued.
- R7: A `cmd_brk_on` pulse drives the line low continuously once any frame in progress has finished, and no character starts during the break. A `cmd_brk_off` pulse returns the line high, and it stays high for exactly 16 `tick16` pulses before a queued character starts.
- R8: While `cfg_cts_auto` is 1 and `cts_ok` is 0, no new character starts. A frame that has already started always completes, even if `cts_ok` drops during it.
- R9: While `cfg_rts_tx` is 1, `rts_out` is high from the clock after a character is accepted until the last stop pulse of the last pending character. It is low when `tx_empty` is high. While `cfg_rts_tx` is 0, `rts_out` stays low.
- R10: `cfg_route` selects the line routing. 0 (normal): `pin_txd` carries the transmitter and `rx_line` carries `pin_rxd`. 1 (echo): both outputs carry `pin_rxd`. 2 (local loopback): `pin_txd` is held high and `rx_line` carries the transmitter. 3 (remote loopback): `pin_txd` carries `pin_rxd` and `rx_line` is held high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick16 | input | 1 | 16x bit-rate enable pulse |
| cfg_len | input | 2 | Character length code |
| cfg_par | input | 3 | Parity code |
| cfg_stop | input | 4 | Stop length code |
| cfg_cts_auto | input | 1 | Wait for `cts_ok` before each character |
| cfg_rts_tx | input | 1 | Drive `rts_out` while sending |
| cfg_route | input | 2 | Line routing selector |
| cmd_brk_on | input | 1 | Pulse: begin break |
| cmd_brk_off | input | 1 | Pulse: end break (wins if both are high) |
| tx_data | input | 8 | Character to send |
| tx_valid | input | 1 | `tx_data` is valid |
| tx_ready | output | 1 | Holding slot is free |
| cts_ok | input | 1 | Clear to send, active high |
| rts_out | output | 1 | Request to send, active high |
| tx_empty | output | 1 | Nothing queued and nothing shifting |
| pin_txd | output | 1 | Serial output pin |
| pin_rxd | input | 1 | Serial input pin |
| rx_line | output | 1 | Line delivered to the receiver side |

## Verification
`tx_ready` falls on the clock that accepts a character. When the shifter is idle, the start bit appears on the next clock. Every later bit boundary falls on a `tick16` edge, and the routing outputs follow their inputs in the same cycle. The bench therefore samples the line at falling clock edges, and only at those where `tick16` is high. It counts these samples bit by bit against a frame it builds arithmetically from the configuration. The enable is spaced two or three clocks apart so that back-to-back frames and the post-break guard time show as exact pulse counts. Flag and RTS checks are taken at falling edges a fixed number of clocks after the accepting edge.

// File: rtl/uatx_pkg.sv
// Package: shared types and helper functions for the UART frame transmitter.
// Assumes the character field is at most 8 bits wide (5..8 data bits).
package uatx_pkg;

    localparam int CHAR_W_MAX = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP,
        ST_BREAK,
        ST_GUARD
    } txst_e;

    typedef enum logic [1:0] {
        RT_NORMAL = 2'd0,
        RT_ECHO   = 2'd1,
        RT_LOCAL  = 2'd2,
        RT_REMOTE = 2'd3
    } route_e;

    // Stop time in enable pulses for a stop-length code.
    function automatic int unsigned stop_ticks(input logic [3:0] code, input int unsigned tpb);
        case (code)
            4'h8:    return tpb + tpb / 2;
            4'hF:    return 2 * tpb;
            default: return tpb;
        endcase
    endfunction

    // Parity bit for the bits that are actually sent.
    function automatic logic char_parity(input logic [CHAR_W_MAX-1:0] d,
                                         input logic [1:0] len,
                                         input logic [2:0] code);
        logic x;
        x = 1'b0;
        for (int i = 0; i < CHAR_W_MAX; i++) begin
            if (i < 5 + int'(len)) x = x ^ d[i];
        end
        case (code[1:0])
            2'd0:    return x;
            2'd1:    return ~x;
            2'd2:    return 1'b0;
            default: return 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/uatx_holdreg.sv
// Module: single-entry holding slot in front of the shifter.
// Accepts on valid&&ready; is emptied by the shifter's take pulse.
// Assumes take is only raised while the slot is full.
module uatx_holdreg #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              in_ready,
    input  logic              take,
    output logic              full,
    output logic [DATA_W-1:0] data
);

    logic accept;

    assign in_ready = ~full;
    assign accept   = in_valid & ~full;

    // Slot occupancy and captured character.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full <= 1'b0;
            data <= '0;
        end else if (accept) begin
            full <= 1'b1;
            data <= in_data;
        end else if (take) begin
            full <= 1'b0;
        end
    end

    // A held character stays put until the shifter takes it.
    p_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !take) |=> (full && $stable(data)));

    // Acceptance fills the slot so no second character can overwrite it.
    p_accept_fills_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready);

endmodule

// File: rtl/uatx_serializer.sv
// Module: frame sequencer and shift stage.
// Sends start, 5..8 data bits LSB first, optional parity and the stop time,
// and handles break and the post-break guard time.
// Assumes tick is a one-clock enable pulse; the format is latched at launch.
module uatx_serializer
    import uatx_pkg::*;
#(
    parameter int TICKS_PER_BIT = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  tick,
    input  logic                  hold_full,
    input  logic [CHAR_W_MAX-1:0] hold_data,
    input  logic [1:0]            len_code,
    input  logic [2:0]            par_code,
    input  logic [3:0]            stop_code,
    input  logic                  cts_auto,
    input  logic                  cts_ok,
    input  logic                  brk_on,
    input  logic                  brk_off,
    output logic                  take,
    output logic                  line,
    output logic                  shifting
);

    localparam int CNT_W = $clog2(2 * TICKS_PER_BIT + 1);
    localparam int IDX_W = $clog2(CHAR_W_MAX);
    localparam logic [CNT_W-1:0] BIT_LAST = CNT_W'(TICKS_PER_BIT - 1);

    txst_e                  state;
    logic [CNT_W-1:0]       cnt;
    logic [IDX_W-1:0]       bit_idx;
    logic [IDX_W-1:0]       last_idx;
    logic [CHAR_W_MAX-1:0]  shreg;
    logic                   par_on;
    logic                   par_bit;
    logic [CNT_W-1:0]       stop_len;
    logic                   brk_req;
    logic                   bit_end;
    logic                   gate_ok;

    assign gate_ok  = ~cts_auto | cts_ok;
    assign take     = (state == ST_IDLE) & ~brk_req & hold_full & gate_ok;
    assign bit_end  = tick & (cnt == BIT_LAST);
    assign shifting = (state == ST_START) | (state == ST_DATA) |
                      (state == ST_PAR)   | (state == ST_STOP);

    // Break request flag: the off command takes priority over the on command.
    always_ff @(posedge clk) begin
        if (!rst_n)       brk_req <= 1'b0;
        else if (brk_off) brk_req <= 1'b0;
        else if (brk_on)  brk_req <= 1'b1;
    end

    // Frame sequencer: advances one bit cell per TICKS_PER_BIT enable pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            cnt      <= '0;
            bit_idx  <= '0;
            last_idx <= '0;
            shreg    <= '0;
            par_on   <= 1'b0;
            par_bit  <= 1'b0;
            stop_len <= CNT_W'(TICKS_PER_BIT);
        end else begin
            case (state)
                ST_IDLE: begin
                    if (brk_req) begin
                        state <= ST_BREAK;
                        cnt   <= '0;
                    end else if (take) begin
                        state    <= ST_START;
                        cnt      <= '0;
                        bit_idx  <= '0;
                        shreg    <= hold_data;
                        last_idx <= IDX_W'(32'd4 + 32'(len_code));
                        par_on   <= ~par_code[2];
                        par_bit  <= char_parity(hold_data, len_code, par_code);
                        stop_len <= CNT_W'(stop_ticks(stop_code, TICKS_PER_BIT));
                    end
                end
                ST_START: begin
                    if (bit_end) begin
                        state <= ST_DATA;
                        cnt   <= '0;
                    end else if (tick) begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_DATA: begin
                    if (bit_end) begin
                        cnt   <= '0;
                        shreg <= shreg >> 1;
                        if (bit_idx == last_idx) begin
                            state <= par_on ? ST_PAR : ST_STOP;
                        end else begin
                            bit_idx <= bit_idx + 1'b1;
                        end
                    end else if (tick) begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_PAR: begin
                    if (bit_end) begin
                        state <= ST_STOP;
                        cnt   <= '0;
                    end else if (tick) begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_STOP: begin
                    if (tick) begin
                        if (cnt == stop_len - CNT_W'(1)) begin
                            state <= ST_IDLE;
                            cnt   <= '0;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                ST_BREAK: begin
                    if (!brk_req) begin
                        state <= ST_GUARD;
                        cnt   <= '0;
                    end
                end
                ST_GUARD: begin
                    if (brk_req) begin
                        state <= ST_BREAK;
                        cnt   <= '0;
                    end else if (bit_end) begin
                        state <= ST_IDLE;
                        cnt   <= '0;
                    end else if (tick) begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Line level for each phase of the frame.
    always_comb begin
        case (state)
            ST_START: line = 1'b0;
            ST_DATA:  line = shreg[0];
            ST_PAR:   line = par_bit;
            ST_BREAK: line = 1'b0;
            default:  line = 1'b1;
        endcase
    end

    // A frame can only begin from the idle state.
    p_start_from_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_START && $past(state) != ST_START) |-> $past(state) == ST_IDLE);

    // The data bit index never passes the configured last bit.
    p_idx_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DATA) |-> bit_idx <= last_idx);

    // The stop counter stays inside the latched stop time.
    p_stop_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STOP) |-> cnt < stop_len);

    // A pending break keeps characters from starting.
    p_break_no_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && brk_req) |=> state != ST_START);

    // With flow control on and CTS low, no frame starts.
    p_cts_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && cts_auto && !cts_ok) |=> state != ST_START);

endmodule

// File: rtl/uatx_router.sv
// Module: channel routing between the transmitter, the pins and the receiver side.
// Purely combinational; assumes the selector is static while traffic runs.
module uatx_router
    import uatx_pkg::*;
(
    input  logic [1:0] route,
    input  logic       tx_line,
    input  logic       pin_rxd,
    output logic       pin_txd,
    output logic       rx_line
);

    // Select both line paths from the routing code.
    always_comb begin
        case (route_e'(route))
            RT_ECHO: begin
                pin_txd = pin_rxd;
                rx_line = pin_rxd;
            end
            RT_LOCAL: begin
                pin_txd = 1'b1;
                rx_line = tx_line;
            end
            RT_REMOTE: begin
                pin_txd = pin_rxd;
                rx_line = 1'b1;
            end
            default: begin
                pin_txd = tx_line;
                rx_line = pin_rxd;
            end
        endcase
    end

endmodule

// File: rtl/uart_frame_tx.sv
// Module: top level of the configurable UART frame transmitter.
// Joins the holding slot, the frame serializer and the line router, and
// derives the ready, empty and RTS outputs.
// Assumes the configuration inputs change only while tx_empty is high.
module uart_frame_tx
    import uatx_pkg::*;
#(
    parameter int TICKS_PER_BIT = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  tick16,
    input  logic [1:0]            cfg_len,
    input  logic [2:0]            cfg_par,
    input  logic [3:0]            cfg_stop,
    input  logic                  cfg_cts_auto,
    input  logic                  cfg_rts_tx,
    input  logic [1:0]            cfg_route,
    input  logic                  cmd_brk_on,
    input  logic                  cmd_brk_off,
    input  logic [CHAR_W_MAX-1:0] tx_data,
    input  logic                  tx_valid,
    output logic                  tx_ready,
    input  logic                  cts_ok,
    output logic                  rts_out,
    output logic                  tx_empty,
    output logic                  pin_txd,
    input  logic                  pin_rxd,
    output logic                  rx_line
);

    logic                  hold_full;
    logic [CHAR_W_MAX-1:0] hold_data;
    logic                  take;
    logic                  tx_line;
    logic                  shifting;

    uatx_holdreg #(.DATA_W(CHAR_W_MAX)) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (tx_valid),
        .in_data  (tx_data),
        .in_ready (tx_ready),
        .take     (take),
        .full     (hold_full),
        .data     (hold_data)
    );

    uatx_serializer #(.TICKS_PER_BIT(TICKS_PER_BIT)) u_ser (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick16),
        .hold_full (hold_full),
        .hold_data (hold_data),
        .len_code  (cfg_len),
        .par_code  (cfg_par),
        .stop_code (cfg_stop),
        .cts_auto  (cfg_cts_auto),
        .cts_ok    (cts_ok),
        .brk_on    (cmd_brk_on),
        .brk_off   (cmd_brk_off),
        .take      (take),
        .line      (tx_line),
        .shifting  (shifting)
    );

    uatx_router u_route (
        .route   (cfg_route),
        .tx_line (tx_line),
        .pin_rxd (pin_rxd),
        .pin_txd (pin_txd),
        .rx_line (rx_line)
    );

    // Status and RTS from slot occupancy and shifter activity.
    assign tx_empty = ~hold_full & ~shifting;
    assign rts_out  = cfg_rts_tx & (hold_full | shifting);

    // Any pending work raises RTS when the option is on.
    p_rts_pending_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rts_tx && !tx_empty) |-> rts_out);

    // An empty transmitter can always accept a character.
    p_empty_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tx_empty |-> tx_ready);

endmodule

// File: tb/uart_frame_tx_tb.sv
`timescale 1ns/100ps
module uart_frame_tx_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick16;
    logic [1:0] cfg_len = 2'd3;
    logic [2:0] cfg_par = 3'b100;
    logic [3:0] cfg_stop = 4'h7;
    logic       cfg_cts_auto = 1'b0;
    logic       cfg_rts_tx = 1'b0;
    logic [1:0] cfg_route = 2'd0;
    logic       cmd_brk_on = 1'b0;
    logic       cmd_brk_off = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic       tx_valid = 1'b0;
    logic       tx_ready;
    logic       cts_ok = 1'b1;
    logic       rts_out;
    logic       tx_empty;
    logic       pin_txd;
    logic       pin_rxd = 1'b1;
    logic       rx_line;

    int  tdiv = 2;
    int  tph = 0;
    int  checks = 0;
    int  errors = 0;
    bit  pending_start = 1'b0;

    always #2.5 clk = ~clk;

    assign tick16 = (tph == 0);
    always @(posedge clk) tph <= (tph + 1 >= tdiv) ? 0 : tph + 1;

    uart_frame_tx dut_i (
        .clk(clk), .rst_n(rst_n), .tick16(tick16),
        .cfg_len(cfg_len), .cfg_par(cfg_par), .cfg_stop(cfg_stop),
        .cfg_cts_auto(cfg_cts_auto), .cfg_rts_tx(cfg_rts_tx), .cfg_route(cfg_route),
        .cmd_brk_on(cmd_brk_on), .cmd_brk_off(cmd_brk_off),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .cts_ok(cts_ok), .rts_out(rts_out), .tx_empty(tx_empty),
        .pin_txd(pin_txd), .pin_rxd(pin_rxd), .rx_line(rx_line)
    );

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic exp_par(input logic [7:0] d, input int len, input int par);
        logic x;
        x = 1'b0;
        for (int i = 0; i < len + 5; i++) x = x ^ d[i];
        case (par & 3)
            0: return x;
            1: return ~x;
            2: return 1'b0;
            default: return 1'b1;
        endcase
    endfunction

    function automatic int exp_stop(input int code);
        if (code == 8) return 24;
        if (code == 15) return 32;
        return 16;
    endfunction

    // One line sample per enable pulse, taken at the falling edge before it.
    task automatic sample(output logic v, output logic r);
        do @(negedge clk); while (!tick16);
        v = pin_txd;
        r = rts_out;
    endtask

    task automatic push(input logic [7:0] d);
        @(negedge clk);
        tx_data  = d;
        tx_valid = 1'b1;
        while (!tx_ready) @(negedge clk);
        @(negedge clk);
        tx_valid = 1'b0;
    endtask

    task automatic pulse_brk(input bit on);
        @(negedge clk);
        if (on) cmd_brk_on = 1'b1; else cmd_brk_off = 1'b1;
        @(negedge clk);
        cmd_brk_on  = 1'b0;
        cmd_brk_off = 1'b0;
    endtask

    // rts_exp: -1 no check, else expected rts level during the frame.
    task automatic check_frame(input logic [7:0] d, input int len, input int par,
                               input int stop_exp, input bit do_stop, input int rts_exp);
        logic v, r;
        int bad = 0;
        int waitc = 0;
        int stopc = 0;
        logic pb;
        if (!pending_start) begin
            v = 1'b1;
            while (v && waitc < 4000) begin
                sample(v, r);
                waitc++;
            end
            if (v) begin
                chk(1'b0, "R4", "no start bit", 1, 0);
                return;
            end
        end
        pending_start = 1'b0;
        for (int i = 1; i < 16; i++) begin
            sample(v, r);
            if (v !== 1'b0) bad++;
            if (rts_exp >= 0 && r !== rts_exp[0]) bad++;
        end
        for (int b = 0; b < len + 5; b++) begin
            for (int i = 0; i < 16; i++) begin
                sample(v, r);
                if (v !== d[b]) bad++;
                if (rts_exp >= 0 && r !== rts_exp[0]) bad++;
            end
        end
        if (par < 4) begin
            pb = exp_par(d, len, par);
            for (int i = 0; i < 16; i++) begin
                sample(v, r);
                if (v !== pb) bad++;
                if (rts_exp >= 0 && r !== rts_exp[0]) bad++;
            end
        end
        chk(bad == 0, "R1 R2 R4 R9", $sformatf("frame d=%02h len=%0d par=%0d mismatches", d, len, par), bad, 0);
        do begin
            sample(v, r);
            if (v) stopc++;
        end while (v && stopc < 64);
        if (!v) pending_start = 1'b1;
        if (do_stop) chk(stopc == stop_exp, "R3", "stop pulses between frames", stopc, stop_exp);
    endtask

    task automatic check_route(input logic txl);
        logic po, rx;
        for (int rt = 0; rt < 4; rt++) begin
            for (int p = 0; p < 2; p++) begin
                cfg_route = rt[1:0];
                pin_rxd   = p[0];
                #1;
                case (rt)
                    1: begin po = p[0]; rx = p[0]; end
                    2: begin po = 1'b1; rx = txl;  end
                    3: begin po = p[0]; rx = 1'b1; end
                    default: begin po = txl; rx = p[0]; end
                endcase
                chk(pin_txd === po && rx_line === rx, "R10",
                    $sformatf("route %0d pin %0d tx %0d (pin_txd,rx_line)", rt, p, txl),
                    {pin_txd, rx_line}, {po, rx});
            end
        end
        cfg_route = 2'd0;
        pin_rxd   = 1'b1;
        #1;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired: actual 1 expected 0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic v, r;
        int lows, highs;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(tx_ready && tx_empty && pin_txd && !rts_out, "R5 R6 R9", "reset state (ready,empty,txd,rts)",
            {tx_ready, tx_empty, pin_txd, rts_out}, 4'b1110);

        // Line routing with the transmitter idle high.
        check_route(1'b1);

        // Format sweep: every length, every parity kind, several data values.
        for (int len = 0; len < 4; len++) begin
            for (int pi = 0; pi < 6; pi++) begin
                for (int k = 0; k < 5; k++) begin
                    int par;
                    logic [7:0] d;
                    par = (pi < 4) ? pi : ((pi == 4) ? 4 : 7);
                    case (k)
                        0: d = 8'h00;
                        1: d = 8'hFF;
                        2: d = 8'hA5;
                        3: d = 8'h3C;
                        default: d = 8'((len * 37 + pi * 11 + 5) & 255);
                    endcase
                    tdiv    = (k == 4) ? 3 : 2;
                    cfg_len = len[1:0];
                    cfg_par = par[2:0];
                    fork
                        push(d);
                        check_frame(d, len, par, 16, 1'b0, 0);
                    join
                end
            end
        end

        // Stop lengths, measured between back-to-back frames (R3).
        cfg_len = 2'd3;
        cfg_par = 3'b000;
        for (int s = 0; s < 5; s++) begin
            int code;
            case (s)
                0: code = 7;
                1: code = 8;
                2: code = 15;
                3: code = 0;
                default: code = 11;
            endcase
            cfg_stop = code[3:0];
            tdiv = (s == 1) ? 3 : 2;
            fork
                begin push(8'h5A); push(8'hC3); end
                begin
                    check_frame(8'h5A, 3, 0, exp_stop(code), 1'b1, -1);
                    check_frame(8'hC3, 3, 0, 16, 1'b0, -1);
                end
            join
        end
        cfg_stop = 4'h7;
        tdiv = 2;

        // Holding slot, flags and RTS with two queued characters (R5 R6 R9).
        cfg_rts_tx = 1'b1;
        fork
            begin
                push(8'h81);
                repeat (40) @(negedge clk);
                chk(tx_ready && !tx_empty, "R5 R6", "slot free while shifting (ready,empty)",
                    {tx_ready, tx_empty}, 2'b10);
                push(8'h7E);
                chk(!tx_ready && !tx_empty, "R5", "slot held behind shifter (ready,empty)",
                    {tx_ready, tx_empty}, 2'b00);
            end
            begin
                check_frame(8'h81, 3, 0, 16, 1'b1, 1);
                check_frame(8'h7E, 3, 0, 16, 1'b0, -1);
            end
        join
        chk(tx_empty && tx_ready && !rts_out, "R6 R9", "idle after queue drains (empty,ready,rts)",
            {tx_empty, tx_ready, rts_out}, 3'b110);

        // CTS gating: nothing starts while blocked; RTS shows the pending character (R8 R9).
        cfg_cts_auto = 1'b1;
        cts_ok       = 1'b0;
        push(8'h96);
        @(negedge clk);
        chk(rts_out && !tx_ready && !tx_empty, "R9 R5", "blocked char pending (rts,ready,empty)",
            {rts_out, tx_ready, tx_empty}, 3'b100);
        lows = 0;
        for (int i = 0; i < 60; i++) begin
            sample(v, r);
            if (!v) lows++;
        end
        chk(lows == 0, "R8", "low samples while CTS blocked", lows, 0);
        cts_ok = 1'b1;
        check_frame(8'h96, 3, 0, 16, 1'b0, 1);

        // CTS dropping mid-frame does not cut the frame short (R8).
        fork
            push(8'h4B);
            begin repeat (80) @(negedge clk); cts_ok = 1'b0; end
            check_frame(8'h4B, 3, 0, 16, 1'b0, 1);
        join
        cts_ok = 1'b1;
        cfg_cts_auto = 1'b0;

        // With the option off, RTS stays low through a frame (R9).
        cfg_rts_tx = 1'b0;
        fork
            push(8'h12);
            check_frame(8'h12, 3, 0, 16, 1'b0, 0);
        join

        // Break while idle: line low, character held off, then guard time (R7 R6).
        pulse_brk(1'b1);
        repeat (6) @(negedge clk);
        chk(tx_empty && tx_ready, "R6", "empty during break with nothing queued (empty,ready)",
            {tx_empty, tx_ready}, 2'b11);
        check_route(1'b0);
        push(8'hE7);
        highs = 0;
        for (int i = 0; i < 80; i++) begin
            sample(v, r);
            if (v) highs++;
        end
        chk(highs == 0, "R7", "high samples during break", highs, 0);
        chk(!tx_ready && !tx_empty, "R7 R5", "char waits during break (ready,empty)",
            {tx_ready, tx_empty}, 2'b00);
        pulse_brk(1'b0);
        highs = 0;
        v = 1'b0;
        while (!v) sample(v, r);
        highs = 1;
        do begin
            sample(v, r);
            if (v) highs++;
        end while (v && highs < 100);
        chk(highs == 16, "R7", "high pulses after break before start", highs, 16);
        pending_start = 1'b1;
        check_frame(8'hE7, 3, 0, 16, 1'b0, -1);

        // Break requested mid-frame: the frame completes, then the line goes low (R7).
        fork
            push(8'h33);
            begin repeat (60) @(negedge clk); pulse_brk(1'b1); end
            check_frame(8'h33, 3, 0, 16, 1'b1, -1);
        join
        pending_start = 1'b0;
        lows = 0;
        for (int i = 0; i < 40; i++) begin
            sample(v, r);
            if (!v) lows++;
        end
        chk(lows == 40, "R7", "low samples after mid-frame break", lows, 40);
        pulse_brk(1'b0);
        repeat (80) @(negedge clk);
        chk(pin_txd && tx_empty, "R7 R6", "idle after break ends (txd,empty)",
            {pin_txd, tx_empty}, 2'b11);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule